// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the 16-bit basic control word of a 10/100 Ethernet transceiver as a management agent sees it. A host writes the whole word through a single-cycle write strobe and reads it back combinationally. The block turns the stored bits, together with a few board straps and live pins, into the effective control signals used by the rest of the transceiver: soft reset, loopback, line speed, auto-negotiation enable, power-down, isolate, a restart request for the negotiation engine, and duplex.

The speed bit follows strict rules. Whether it can be written, whether it is overridden, and whether it matters at all depends on the stored negotiation-enable bit and on a 3-bit technology code that can change at any time. The negotiation-enable bit is also held off by a strap. Soft reset and negotiation restart are self-clearing: they read back as 1 for one cycle and then drop.

Top module: `phy_ctrl_reg`

## Requirements
- R1: A low `rst_n` sampled at a clock edge loads the defaults. After reset `rd_data` reads soft-reset bit 15 = 0, loopback bit 14 = 0, speed bit 13 = 1, negotiation bit 12 = `aneg_allow`, power-down bit 11 = 0, isolate bit 10 = `iso_default`, restart bit 9 = 0 and duplex bit 8 = 0. Bits 7..0 always read 0.
- R2: A write with bit 15 = 1 sets bit 15 and `soft_rst` for exactly the next cycle. On the clock after that, every bit returns to its R1 default and any write in that cycle is discarded.
- R3: Bit 14 is read/write and drives `loopback` directly.
- R4: While bit 12 = 0 and `tech_sel` = 3'b000, a write loads bit 13. In that state `speed_100` equals bit 13 (1 = 100 Mb/s, 0 = 10 Mb/s).
- R5: While bit 12 = 0, `tech_sel` = 3'b001 (10-only) drives bit 13 to 0 on every clock, and `tech_sel` = 3'b010 (100-only) drives it to 1. Written values of bit 13 are ignored in both cases.
- R6: While bit 12 = 1, writes do not change bit 13 and `speed_100` reads 1 whatever bit 13 holds.
- R7: When `tech_sel` goes back to 3'b000 from a nonzero code, bit 13 keeps its value until a write changes it. Codes 3'b011 to 3'b111 neither override bit 13 nor allow it to be written.
- R8: While `aneg_allow` = 0, bit 12 is cleared on every clock and cannot be set. When `aneg_allow` rises, bit 12 stays 0 until a write sets it. `aneg_en` equals bit 12.
- R9: Bit 11 is read/write, and `pwr_down` = bit 11 OR `pdn_pin`. Reads and writes keep working while powered down.
- R10: Bit 10 is read/write with a reset value of `iso_default`, and `isolate` = bit 10 OR `iso_pin`. Reads and writes keep working while isolated.
- R11: A write with bit 9 = 1 makes bit 9 and `aneg_restart` high for exactly the next cycle. They then clear unless bit 9 is written again.
- R12: Bit 8 is read/write with a reset value of 0 and drives `duplex`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Word to write |
| rd_data | output | 16 | Stored control word, read combinationally |
| tech_sel | input | 3 | Technology code: 000 any, 001 10-only, 010 100-only, other any |
| aneg_allow | input | 1 | Strap permitting auto-negotiation |
| iso_default | input | 1 | Strap giving the reset value of the isolate bit |
| iso_pin | input | 1 | External isolate request |
| pdn_pin | input | 1 | External power-down request |
| soft_rst | output | 1 | Soft reset, high for the one cycle before defaults load |
| loopback | output | 1 | Loopback mode |
| speed_100 | output | 1 | Effective speed, 1 = 100 Mb/s |
| aneg_en | output | 1 | Auto-negotiation enabled |
| pwr_down | output | 1 | Effective power-down |
| isolate | output | 1 | Effective isolate |
| aneg_restart | output | 1 | One-cycle negotiation restart request |
| duplex | output | 1 | Full duplex selected |

## Verification
The bench drives writes to the speed bit under each technology code, both with negotiation on and with it off. If writability were gated on negotiation alone, the bit would take the written value under codes 011 to 111. If the override were applied to the output only, the speed would snap back when the code returns to 000, where it should keep the overridden value. A bench model also follows the strap on the negotiation bit: it lowers `aneg_allow`, attempts a set, and raises the strap again. A design that reloaded the bit from the strap would show negotiation enabled without any write. Self-clearing bits are sampled on both cycles after their write, which exposes a soft reset that applies defaults too early or a restart pulse that lasts two cycles.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;

   // bit positions inside the control word
   localparam int B_SRST  = 15;
   localparam int B_LOOP  = 14;
   localparam int B_SPEED = 13;
   localparam int B_ANEG  = 12;
   localparam int B_PDN   = 11;
   localparam int B_ISO   = 10;
   localparam int B_RSTRT = 9;
   localparam int B_DUP   = 8;

   // technology codes
   localparam logic [2:0] TECH_ANY  = 3'b000;
   localparam logic [2:0] TECH_10   = 3'b001;
   localparam logic [2:0] TECH_100  = 3'b010;

   typedef enum logic [1:0] {
      CAP_FREE   = 2'd0,
      CAP_ONLY10 = 2'd1,
      CAP_ONLY100 = 2'd2
   } speed_cap_e;

   function automatic speed_cap_e decode_cap(input logic [2:0] code);
      case (code)
         TECH_10:  decode_cap = CAP_ONLY10;
         TECH_100: decode_cap = CAP_ONLY100;
         default:  decode_cap = CAP_FREE;
      endcase
   endfunction

endpackage

// File: rtl/pcr_sc_bits.sv
module pcr_sc_bits #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] set_vec,
   output logic [N-1:0] q
);

   generate
      if (N < 1) begin : g_bad_n
         $error("pcr_sc_bits: N must be at least 1");
      end
   endgenerate

   genvar i;
   generate
      for (i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)   q[i] <= 1'b0;
            else if (clr) q[i] <= 1'b0;
            else          q[i] <= set_vec[i];
         end

         // R2 R11
         sc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !set_vec[i]) |=> !q[i]);
      end
   endgenerate

endmodule

// File: rtl/pcr_aneg_bit.sv
module pcr_aneg_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   input  logic wr,
   input  logic wd,
   input  logic allow,
   output logic q
);

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= allow;
      else if (srst)   q <= allow;
      else if (!allow) q <= 1'b0;
      else if (wr)     q <= wd;
   end

   // R8
   aneg_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !allow |=> !q);

   // R8
   aneg_no_self_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!q && !wr && !srst) |=> !q);

endmodule

// File: rtl/pcr_speed_bit.sv
module pcr_speed_bit import phy_ctrl_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       srst,
   input  logic       wr,
   input  logic       wd,
   input  logic       aneg_q,
   input  speed_cap_e cap,
   input  logic       tech_zero,
   output logic       q,
   output logic       speed_eff
);

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= 1'b1;
      else if (srst)   q <= 1'b1;
      else if (!aneg_q) begin
         case (cap)
            CAP_ONLY10:  q <= 1'b0;
            CAP_ONLY100: q <= 1'b1;
            default:     if (wr && tech_zero) q <= wd;
         endcase
      end
   end

   assign speed_eff = aneg_q ? 1'b1 : q;

   // R5
   force_ten_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!aneg_q && cap == CAP_ONLY10 && !srst) |=> !q);

   // R5
   force_hundred_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!aneg_q && cap == CAP_ONLY100 && !srst) |=> q);

   // R6
   aneg_locks_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (aneg_q && !srst) |=> $stable(q));

   // R7
   other_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap == CAP_FREE && !tech_zero && !srst) |=> $stable(q));

endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg import phy_ctrl_pkg::*; #(
   parameter int REG_W  = 16,
   parameter int TECH_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic [TECH_W-1:0] tech_sel,
   input  logic              aneg_allow,
   input  logic              iso_default,
   input  logic              iso_pin,
   input  logic              pdn_pin,
   output logic              soft_rst,
   output logic              loopback,
   output logic              speed_100,
   output logic              aneg_en,
   output logic              pwr_down,
   output logic              isolate,
   output logic              aneg_restart,
   output logic              duplex
);

   localparam int SC_N   = 2;
   localparam int SC_RST = 1;
   localparam int SC_RAN = 0;
   localparam int LOW_W  = B_DUP;

   generate
      if (REG_W != 16) begin : g_bad_w
         $error("phy_ctrl_reg: REG_W must be 16");
      end
      if (TECH_W != 3) begin : g_bad_t
         $error("phy_ctrl_reg: TECH_W must be 3");
      end
   endgenerate

   logic [SC_N-1:0] sc_q;
   logic [SC_N-1:0] sc_set;
   logic            srst;
   logic            lp_q, pd_q, iso_q, dup_q;
   logic            spd_q, an_q;
   speed_cap_e      cap;
   logic            unused_low;

   assign unused_low = ^wr_data[LOW_W-1:0];
   assign srst       = sc_q[SC_RST];
   assign cap        = decode_cap(tech_sel);

   assign sc_set[SC_RST] = wr_en & wr_data[B_SRST];
   assign sc_set[SC_RAN] = wr_en & wr_data[B_RSTRT];

   pcr_sc_bits #(.N(SC_N)) u_sc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (srst),
      .set_vec (sc_set),
      .q       (sc_q)
   );

   pcr_aneg_bit u_aneg (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst),
      .wr    (wr_en),
      .wd    (wr_data[B_ANEG]),
      .allow (aneg_allow),
      .q     (an_q)
   );

   pcr_speed_bit u_speed (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (srst),
      .wr        (wr_en),
      .wd        (wr_data[B_SPEED]),
      .aneg_q    (an_q),
      .cap       (cap),
      .tech_zero (tech_sel == TECH_ANY),
      .q         (spd_q),
      .speed_eff (speed_100)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || srst) begin
         lp_q  <= 1'b0;
         pd_q  <= 1'b0;
         iso_q <= iso_default;
         dup_q <= 1'b0;
      end else if (wr_en) begin
         lp_q  <= wr_data[B_LOOP];
         pd_q  <= wr_data[B_PDN];
         iso_q <= wr_data[B_ISO];
         dup_q <= wr_data[B_DUP];
      end
   end

   always_comb begin
      rd_data          = '0;
      rd_data[B_SRST]  = sc_q[SC_RST];
      rd_data[B_LOOP]  = lp_q;
      rd_data[B_SPEED] = spd_q;
      rd_data[B_ANEG]  = an_q;
      rd_data[B_PDN]   = pd_q;
      rd_data[B_ISO]   = iso_q;
      rd_data[B_RSTRT] = sc_q[SC_RAN];
      rd_data[B_DUP]   = dup_q;
   end

   assign soft_rst     = sc_q[SC_RST];
   assign aneg_restart = sc_q[SC_RAN];
   assign loopback     = lp_q;
   assign aneg_en      = an_q;
   assign duplex       = dup_q;
   assign pwr_down     = pd_q | pdn_pin;
   assign isolate      = iso_q | iso_pin;

   // R2
   soft_reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!soft_rst && !loopback && rd_data[B_SPEED] && !rd_data[B_PDN]
                    && !aneg_restart && !duplex));

   // R9
   pdn_pin_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pdn_pin |-> pwr_down);

   // R10
   iso_pin_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iso_pin |-> isolate);

   // R6
   aneg_speed_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aneg_en |-> speed_100);

endmodule

// File: tb/sim_phy_ctrl_reg.sv
module sim_phy_ctrl_reg;

   localparam int CLK_PERIOD = 10;
   localparam int N_RAND     = 600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [2:0]  tech_sel = 3'b000;
   logic        aneg_allow = 1'b1;
   logic        iso_default = 1'b1;
   logic        iso_pin = 1'b0;
   logic        pdn_pin = 1'b0;
   logic        soft_rst, loopback, speed_100, aneg_en;
   logic        pwr_down, isolate, aneg_restart, duplex;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // model of the stored bits
   logic m_rst, m_lp, m_spd, m_an, m_pd, m_iso, m_rs, m_dup;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_ctrl_reg u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .tech_sel(tech_sel), .aneg_allow(aneg_allow), .iso_default(iso_default),
      .iso_pin(iso_pin), .pdn_pin(pdn_pin), .soft_rst(soft_rst), .loopback(loopback),
      .speed_100(speed_100), .aneg_en(aneg_en), .pwr_down(pwr_down), .isolate(isolate),
      .aneg_restart(aneg_restart), .duplex(duplex)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word();
      return {m_rst, m_lp, m_spd, m_an, m_pd, m_iso, m_rs, m_dup, 8'h00};
   endfunction

   task automatic compare_all();
      check("R1 rd_data", rd_data, exp_word());
      check("R2 soft_rst", {15'd0, soft_rst}, {15'd0, m_rst});
      check("R3 loopback", {15'd0, loopback}, {15'd0, m_lp});
      check("R4 R6 speed_100", {15'd0, speed_100}, {15'd0, m_an ? 1'b1 : m_spd});
      check("R8 aneg_en", {15'd0, aneg_en}, {15'd0, m_an});
      check("R9 pwr_down", {15'd0, pwr_down}, {15'd0, m_pd | pdn_pin});
      check("R10 isolate", {15'd0, isolate}, {15'd0, m_iso | iso_pin});
      check("R11 aneg_restart", {15'd0, aneg_restart}, {15'd0, m_rs});
      check("R12 duplex", {15'd0, duplex}, {15'd0, m_dup});
   endtask

   // one clock: model next state from inputs held across the edge
   task automatic cyc();
      logic n_rst, n_lp, n_spd, n_an, n_pd, n_iso, n_rs, n_dup;
      if (!rst_n || m_rst) begin
         n_rst = 0; n_lp = 0; n_spd = 1; n_an = aneg_allow;
         n_pd = 0; n_iso = iso_default; n_rs = 0; n_dup = 0;
      end else begin
         n_rst = wr_en & wr_data[15];
         n_rs  = wr_en & wr_data[9];
         n_lp  = wr_en ? wr_data[14] : m_lp;
         n_pd  = wr_en ? wr_data[11] : m_pd;
         n_iso = wr_en ? wr_data[10] : m_iso;
         n_dup = wr_en ? wr_data[8]  : m_dup;
         n_an  = !aneg_allow ? 1'b0 : (wr_en ? wr_data[12] : m_an);
         n_spd = m_spd;
         if (!m_an) begin
            if (tech_sel == 3'b001)      n_spd = 1'b0;
            else if (tech_sel == 3'b010) n_spd = 1'b1;
            else if (tech_sel == 3'b000 && wr_en) n_spd = wr_data[13];
         end
      end
      @(posedge clk);
      @(negedge clk);
      m_rst = n_rst; m_lp = n_lp; m_spd = n_spd; m_an = n_an;
      m_pd = n_pd; m_iso = n_iso; m_rs = n_rs; m_dup = n_dup;
      if (rst_n) compare_all();
   endtask

   task automatic wr(input logic [15:0] d);
      wr_en = 1'b1; wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   initial begin
      logic [31:0] r;
      void'($urandom(32'd2024));
      repeat (3) cyc();
      rst_n = 1'b1;
      // R1 reset state with both straps high
      check("R1 reset word", rd_data, 16'h3400);
      check("R1 reset speed", {15'd0, speed_100}, 16'd1);

      wr(16'h0000);
      check("R6 speed write ignored while aneg on", rd_data, 16'h2000);
      wr(16'h0000);
      check("R4 speed written to 10", rd_data, 16'h0000);
      check("R4 speed_100 low", {15'd0, speed_100}, 16'd0);
      tech_sel = 3'b010; cyc();
      check("R5 100-only forces bit 13", rd_data, 16'h2000);
      tech_sel = 3'b000; cyc();
      check("R7 bit 13 retained on return to 000", rd_data, 16'h2000);
      wr(16'h0000);
      check("R4 speed writable again", rd_data, 16'h0000);
      tech_sel = 3'b001; wr(16'h2000);
      check("R5 10-only ignores write of 1", rd_data, 16'h0000);
      tech_sel = 3'b101; wr(16'h2000);
      check("R7 code 101 blocks write", rd_data, 16'h0000);
      tech_sel = 3'b000;
      aneg_allow = 1'b0; wr(16'h1000);
      check("R8 aneg blocked by strap", rd_data, 16'h0000);
      aneg_allow = 1'b1; cyc();
      check("R8 aneg stays 0 after strap rise", {15'd0, aneg_en}, 16'd0);
      wr(16'h1000);
      check("R8 aneg set by write", rd_data, 16'h1000);
      check("R6 speed_100 high with aneg on", {15'd0, speed_100}, 16'd1);
      wr(16'h4100);
      check("R3 R12 loopback and duplex", rd_data, 16'h4100);
      pdn_pin = 1'b1; iso_pin = 1'b1; cyc();
      check("R9 pin power-down", {15'd0, pwr_down}, 16'd1);
      check("R10 pin isolate", {15'd0, isolate}, 16'd1);
      check("R9 R10 bits untouched by pins", rd_data, 16'h4100);
      pdn_pin = 1'b0; iso_pin = 1'b0;
      wr(16'h4D00);
      check("R9 R10 register bits settable", rd_data, 16'h4D00);
      wr(16'h4F00);
      check("R11 restart reads 1", {15'd0, aneg_restart}, 16'd1);
      cyc();
      check("R11 restart cleared", rd_data, 16'h4D00);
      wr(16'h8000);
      check("R2 soft reset bit visible", rd_data, 16'h8000);
      wr(16'h4100);
      check("R2 defaults restored, write discarded", rd_data, 16'h3400);

      for (int i = 0; i < N_RAND; i++) begin
         r = $urandom();
         wr_en   = r[0];
         wr_data = 16'($urandom());
         if (r[7:4] != 4'd0) wr_data[15] = 1'b0;
         case (r[9:8])
            2'd0: tech_sel = 3'b000;
            2'd1: tech_sel = 3'b001;
            2'd2: tech_sel = 3'b010;
            default: tech_sel = 3'($urandom());
         endcase
         aneg_allow = (r[13:10] != 4'd0);
         pdn_pin    = (r[16:14] == 3'd0);
         iso_pin    = (r[19:17] == 3'd0);
         iso_default = r[20];
         cyc();
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule